// File: doc/BRIEF.md
# Sleep Wake-Up Controller

This block decides when a sleeping low-power radio transceiver wakes. A slow oscillator tick is scaled down by a programmable prescaler to make a wake timebase. An interval counter on that timebase ends the sleep period after a programmed number of timebase periods. The radio can also be woken early by a pulse from its RF-energy detector, or by a request from the host.

Every wake-up raises one interrupt line to the host and records which sources caused it. The wake-up also starts a pin sequence on the active-low transmit/receive control pin. The block counts a programmed number of output-clock periods, drives the pin low for one output-clock period, and then lets it return high. The host puts the radio back to sleep with a sleep command. That command also restarts the timed interval.

The oscillator tick and the output-clock tick arrive as single-cycle enables on the one system clock. Configuration is written through a simple address/data write port.

Top module: `wkup_ctrl`

## Requirements
- R1: A write with `reg_we` high stores `reg_wdata` into the prescaler register at address 0x14, the interval register at address 0x15, or the pin-delay register at address 0x17. A write to any other address changes no behaviour. All three registers reset to 0.
- R2: While asleep, the wake timebase advances once for every N accepted oscillator ticks, where N is the prescaler value. A prescaler value of 0 behaves as N = 1.
- R3: With interval value T > 0, a timed wake-up occurs at the clock edge of the (N*T)-th oscillator tick counted since sleep began. The interval value 0 disables timed wake-up.
- R4: A high `rf_sniff` while asleep wakes the block at the next clock edge and sets `wake_src` bit 1.
- R5: A high `host_wake` while asleep wakes the block and sets `wake_src` bit 2. A timed wake sets bit 0. While awake, all three sources are ignored and `asleep` stays 0.
- R6: A wake-up sets `irq` at the same clock edge at which `asleep` falls. `irq` then holds until `irq_clr`. `irq_clr` clears `irq` and `wake_src`, but a wake-up in the same cycle wins: `irq` stays 1 and `wake_src` holds only the new sources.
- R7: Sources that fire in the same cycle all set their `wake_src` bits under one interrupt. Bits from an uncleared earlier wake-up are kept.
- R8: `trx_n` is high while asleep. After a wake-up, the block counts D output-clock ticks, where D is the pin-delay value. On the following clock edge `trx_n` goes low. It returns high at the next output-clock tick and stays high.
- R9: `sleep_cmd` puts an awake block to sleep at the next edge and restarts the prescaler and interval counts. While asleep, it restarts those counts, and an oscillator tick in the same cycle is not counted.
- R10: After reset, `asleep` = 1, `irq` = 0, `wake_src` = 0 and `trx_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| osc_tick | input | 1 | Single-cycle slow-oscillator enable |
| oclk_tick | input | 1 | Single-cycle output-clock enable |
| rf_sniff | input | 1 | RF energy detected |
| host_wake | input | 1 | Host wake request |
| sleep_cmd | input | 1 | Host command to enter sleep |
| irq_clr | input | 1 | Host clear of interrupt and source field |
| irq | output | 1 | Wake-up interrupt flag |
| wake_src | output | 3 | Wake causes: bit0 timer, bit1 RF, bit2 host |
| asleep | output | 1 | Block is in the sleep state |
| trx_n | output | 1 | Active-low transmit/receive control pin |

## Verification
Two pairs of events can fall in the same cycle. In the first, a timer expiry lands together with an RF detect and a host request. In the second, a fresh wake-up arrives while the host is clearing an earlier interrupt. Directed steps set the prescaler and interval to 1, so that a single oscillator tick expires the timer, and then assert all three sources on that tick. Another directed step raises `irq_clr` together with an RF detect. In both cases the bench expects one raised interrupt, with `wake_src` holding exactly the sources of the new wake-up. The random phase produces further coincidences, and a per-cycle model computed from the requirements judges each one.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    localparam int CFG_W  = 8;
    localparam int ADDR_W = 8;
    localparam int SRC_W  = 3;

    typedef logic [CFG_W-1:0]  cnt_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADDR_PRESCALE = 8'h14;
    localparam addr_t ADDR_INTERVAL = 8'h15;
    localparam addr_t ADDR_PINDELAY = 8'h17;
    localparam cnt_t  CNT_ONE       = cnt_t'(1);

    typedef struct packed {
        cnt_t prescale;
        cnt_t interval;
        cnt_t pin_delay;
    } cfg_t;

    // bit order matters: host = bit2, rf = bit1, timer = bit0
    typedef struct packed {
        logic host;
        logic rf;
        logic timer;
    } src_t;

    typedef enum logic [1:0] {
        PIN_IDLE,
        PIN_WAIT,
        PIN_LOW,
        PIN_DONE
    } pin_phase_e;

    function automatic cnt_t eff_div(input cnt_t raw);
        return (raw == '0) ? CNT_ONE : raw;
    endfunction

endpackage

// File: rtl/wkup_regs.sv
module wkup_regs
    import wkup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t addr,
    input  cnt_t  wdata,
    output cfg_t  cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            unique case (addr)
                ADDR_PRESCALE: cfg.prescale  <= wdata;
                ADDR_INTERVAL: cfg.interval  <= wdata;
                ADDR_PINDELAY: cfg.pin_delay <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wkup_timebase.sv
module wkup_timebase
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic asleep,
    input  logic osc_tick,
    input  logic sleep_cmd,
    input  logic restart,
    input  cnt_t prescale,
    input  cnt_t interval,
    output logic tfire
);

    cnt_t pre_cnt;
    cnt_t int_cnt;
    cnt_t div_eff;
    logic tick_ok;
    logic div_hit;

    always_comb begin
        div_eff = eff_div(prescale);
        tick_ok = asleep && osc_tick && !sleep_cmd;
        div_hit = tick_ok && (pre_cnt >= div_eff - CNT_ONE);
        tfire   = div_hit && (interval != '0) && (int_cnt >= interval - CNT_ONE);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            int_cnt <= '0;
        end else if (tick_ok) begin
            if (div_hit) begin
                pre_cnt <= '0;
                int_cnt <= int_cnt + CNT_ONE;
            end else begin
                pre_cnt <= pre_cnt + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/wkup_pin_seq.sv
module wkup_pin_seq
    import wkup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake,
    input  logic sleep_cmd,
    input  logic oclk_tick,
    input  cnt_t pin_delay,
    output logic trx_n
);

    pin_phase_e phase;
    cnt_t       dly_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PIN_IDLE;
            dly_cnt <= '0;
        end else if (wake) begin
            phase   <= PIN_WAIT;
            dly_cnt <= '0;
        end else if (sleep_cmd) begin
            phase   <= PIN_IDLE;
            dly_cnt <= '0;
        end else begin
            unique case (phase)
                PIN_WAIT: begin
                    if (dly_cnt >= pin_delay) begin
                        phase <= PIN_LOW;
                    end else if (oclk_tick) begin
                        dly_cnt <= dly_cnt + CNT_ONE;
                    end
                end
                PIN_LOW: begin
                    if (oclk_tick) begin
                        phase <= PIN_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign trx_n = (phase != PIN_LOW);

endmodule

// File: rtl/wkup_ctrl.sv
module wkup_ctrl
    import wkup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    input  logic              osc_tick,
    input  logic              oclk_tick,
    input  logic              rf_sniff,
    input  logic              host_wake,
    input  logic              sleep_cmd,
    input  logic              irq_clr,
    output logic              irq,
    output logic [SRC_W-1:0]  wake_src,
    output logic              asleep,
    output logic              trx_n
);

    cfg_t cfg;
    logic tfire;
    src_t hits;
    src_t src_q;
    logic wake;

    wkup_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    wkup_timebase u_tbase (
        .clk       (clk),
        .rst       (rst),
        .asleep    (asleep),
        .osc_tick  (osc_tick),
        .sleep_cmd (sleep_cmd),
        .restart   (sleep_cmd | wake),
        .prescale  (cfg.prescale),
        .interval  (cfg.interval),
        .tfire     (tfire)
    );

    always_comb begin
        hits.timer = asleep && tfire;
        hits.rf    = asleep && rf_sniff;
        hits.host  = asleep && host_wake;
        wake       = |hits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b1;
            irq    <= 1'b0;
            src_q  <= '0;
        end else begin
            if (wake) begin
                asleep <= 1'b0;
            end else if (sleep_cmd) begin
                asleep <= 1'b1;
            end
            irq   <= wake | (irq & ~irq_clr);
            src_q <= (irq_clr ? src_t'('0) : src_q) | hits;
        end
    end

    assign wake_src = src_q;

    wkup_pin_seq u_pin (
        .clk       (clk),
        .rst       (rst),
        .wake      (wake),
        .sleep_cmd (sleep_cmd),
        .oclk_tick (oclk_tick),
        .pin_delay (cfg.pin_delay),
        .trx_n     (trx_n)
    );

endmodule

// File: rtl/wkup_ctrl_chk.sv
module wkup_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_cmd,
    input logic       irq_clr,
    input logic       irq,
    input logic [2:0] wake_src,
    input logic       asleep,
    input logic       trx_n
);

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    // R6
    irq_on_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> irq);

    // R7
    src_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wake_src != 3'b000));

    // R8
    pin_high_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> trx_n);

    // R9
    sleep_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_cmd && !asleep) |=> asleep);

    // R5
    stay_awake_chk: assert property (@(posedge clk) disable iff (rst)
        (!asleep && !sleep_cmd) |=> !asleep);

endmodule

bind wkup_ctrl wkup_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_cmd (sleep_cmd),
    .irq_clr   (irq_clr),
    .irq       (irq),
    .wake_src  (wake_src),
    .asleep    (asleep),
    .trx_n     (trx_n)
);

// File: tb/tb_wkup_ctrl.sv
`timescale 1ns/1ps
module tb_wkup_ctrl;

    localparam int MAX_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       osc_tick = 1'b0;
    logic       oclk_tick = 1'b0;
    logic       rf_sniff = 1'b0;
    logic       host_wake = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic [2:0] wake_src;
    logic       asleep;
    logic       trx_n;

    int vec = 0;
    int bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    wkup_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .osc_tick  (osc_tick),
        .oclk_tick (oclk_tick),
        .rf_sniff  (rf_sniff),
        .host_wake (host_wake),
        .sleep_cmd (sleep_cmd),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .wake_src  (wake_src),
        .asleep    (asleep),
        .trx_n     (trx_n)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model built from the requirements ----------
    logic [7:0] m_pre, m_int, m_dly;
    logic [7:0] m_pcnt, m_ecnt, m_dcnt;
    logic [1:0] m_ph;       // 0 idle, 1 wait, 2 low, 3 done
    logic       m_asleep, m_irq;
    logic [2:0] m_src;

    function automatic int eff_n(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_int = 0; m_dly = 0;
            m_pcnt = 0; m_ecnt = 0; m_dcnt = 0; m_ph = 0;
            m_asleep = 1; m_irq = 0; m_src = 0;
        end else begin
            logic       tick_ok, hit, tf, wk;
            logic [2:0] h;
            tick_ok = m_asleep && osc_tick && !sleep_cmd;
            hit = tick_ok && (int'(m_pcnt) >= eff_n(m_pre) - 1);
            tf  = hit && (m_int != 0) && (int'(m_ecnt) >= int'(m_int) - 1);
            h   = m_asleep ? {host_wake, rf_sniff, tf} : 3'b000;
            wk  = |h;
            if (wk) begin m_ph = 1; m_dcnt = 0; end
            else if (sleep_cmd) begin m_ph = 0; m_dcnt = 0; end
            else if (m_ph == 1) begin
                if (m_dcnt >= m_dly) m_ph = 2;
                else if (oclk_tick) m_dcnt = m_dcnt + 1;
            end else if (m_ph == 2 && oclk_tick) m_ph = 3;
            if (sleep_cmd || wk) begin m_pcnt = 0; m_ecnt = 0; end
            else if (tick_ok) begin
                if (hit) begin m_pcnt = 0; m_ecnt = m_ecnt + 1; end
                else m_pcnt = m_pcnt + 1;
            end
            m_src = (irq_clr ? 3'b000 : m_src) | h;
            m_irq = wk | (m_irq & ~irq_clr);
            if (wk) m_asleep = 0; else if (sleep_cmd) m_asleep = 1;
            if (reg_we) begin
                if (reg_addr == 8'h14) m_pre = reg_wdata;
                if (reg_addr == 8'h15) m_int = reg_wdata;
                if (reg_addr == 8'h17) m_dly = reg_wdata;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R6 irq vs model", int'(irq), int'(m_irq));
            check("R7 wake_src vs model", int'(wake_src), int'(m_src));
            check("R9 asleep vs model", int'(asleep), int'(m_asleep));
            check("R8 trx_n vs model", int'(trx_n), int'(m_ph != 2));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 0;
    endtask

    task automatic pulse_sleep();
        sleep_cmd = 1; cyc(); sleep_cmd = 0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1; cyc(); irq_clr = 0;
    endtask

    task automatic ticks_to_wake(output int n);
        n = 0;
        osc_tick = 1;
        for (int i = 1; i <= 2000; i++) begin
            cyc();
            n = i;
            if (!asleep) break;
        end
        osc_tick = 0;
    endtask

    initial begin
        #(MAX_CYC * 5.0);
        if (!done) begin
            bad++; vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int seed;
        seed = int'($urandom(32'd4242));
        cyc(); cyc();
        rst = 0;
        cyc();
        cmp_on = 1;
        // R10 reset state
        check("R10 asleep", int'(asleep), 1);
        check("R10 irq", int'(irq), 0);
        check("R10 wake_src", int'(wake_src), 0);
        check("R10 trx_n", int'(trx_n), 1);

        // R2: prescaler 0 acts as divide-by-1
        wr(8'h14, 8'd0); wr(8'h15, 8'd2);
        pulse_sleep();
        ticks_to_wake(n);
        check("R2 prescale0 ticks", n, 2);
        check("R5 timer bit", int'(wake_src), 3'b001);
        pulse_clr();

        // R3: 3 x 4 ticks
        wr(8'h14, 8'd3); wr(8'h15, 8'd4);
        pulse_sleep();
        ticks_to_wake(n);
        check("R3 timed wake ticks", n, 12);
        pulse_clr();

        // R3: interval 0 never fires
        wr(8'h15, 8'd0);
        pulse_sleep();
        osc_tick = 1;
        for (int i = 0; i < 600; i++) cyc();
        osc_tick = 0;
        check("R3 interval0 asleep", int'(asleep), 1);

        // R4: RF detect
        rf_sniff = 1; cyc(); rf_sniff = 0;
        check("R4 rf wake asleep", int'(asleep), 0);
        check("R4 rf src", int'(wake_src), 3'b010);
        check("R6 irq set", int'(irq), 1);

        // R5: sources ignored while awake
        rf_sniff = 1; host_wake = 1; cyc(); rf_sniff = 0; host_wake = 0;
        check("R5 awake ignore src", int'(wake_src), 3'b010);
        check("R5 awake stays", int'(asleep), 0);

        // R6: clear alone
        pulse_clr();
        check("R6 clr irq", int'(irq), 0);
        check("R6 clr src", int'(wake_src), 0);

        // R5: host wake
        pulse_sleep();
        host_wake = 1; cyc(); host_wake = 0;
        check("R5 host src", int'(wake_src), 3'b100);
        pulse_clr();

        // R7: timer, RF and host in one cycle
        wr(8'h14, 8'd1); wr(8'h15, 8'd1);
        pulse_sleep();
        osc_tick = 1; rf_sniff = 1; host_wake = 1; cyc();
        osc_tick = 0; rf_sniff = 0; host_wake = 0;
        check("R7 all sources", int'(wake_src), 3'b111);
        check("R7 one irq", int'(irq), 1);

        // R6: wake wins over clear in the same cycle
        pulse_sleep();
        rf_sniff = 1; irq_clr = 1; cyc(); rf_sniff = 0; irq_clr = 0;
        check("R6 wake beats clr irq", int'(irq), 1);
        check("R6 wake beats clr src", int'(wake_src), 3'b010);
        pulse_clr();

        // R8: delay 2 with an output-clock tick every cycle
        wr(8'h17, 8'd2);
        pulse_sleep();
        oclk_tick = 1;
        host_wake = 1; cyc(); host_wake = 0;
        check("R8 pin high at wake", int'(trx_n), 1);
        for (int k = 1; k <= 6; k++) begin
            cyc();
            check("R8 pin sequence", int'(trx_n), (k == 3) ? 0 : 1);
        end
        oclk_tick = 0;
        pulse_clr();

        // R1: writes to other addresses are ignored
        wr(8'h15, 8'd3); wr(8'h14, 8'd1);
        wr(8'h16, 8'd9); wr(8'h05, 8'd9);
        pulse_sleep();
        ticks_to_wake(n);
        check("R1 foreign addr ignored", n, 3);
        pulse_clr();

        // R9: sleep command while asleep restarts the interval
        wr(8'h15, 8'd4);
        pulse_sleep();
        osc_tick = 1; cyc(); cyc(); cyc();
        sleep_cmd = 1; cyc(); sleep_cmd = 0;
        cyc(); cyc(); cyc();
        osc_tick = 0;
        check("R9 restart still asleep", int'(asleep), 1);
        osc_tick = 1; cyc(); osc_tick = 0;
        check("R9 restart wake", int'(asleep), 0);
        pulse_clr();

        // random phase, judged by the model every cycle
        for (int i = 0; i < 6000; i++) begin
            int r;
            osc_tick  = ($urandom % 100) < 40;
            oclk_tick = ($urandom % 100) < 30;
            rf_sniff  = ($urandom % 100) < 2;
            host_wake = ($urandom % 100) < 2;
            irq_clr   = ($urandom % 100) < 6;
            sleep_cmd = ($urandom % 100) < (asleep ? 1 : 8);
            r = $urandom % 100;
            reg_we    = r < 4;
            case ($urandom % 5)
                0: reg_addr = 8'h14;
                1: reg_addr = 8'h15;
                2: reg_addr = 8'h17;
                3: reg_addr = 8'h16;
                default: reg_addr = 8'($urandom);
            endcase
            reg_wdata = 8'($urandom % 6);
            cyc();
        end
        {osc_tick, oclk_tick, rf_sniff, host_wake, irq_clr, sleep_cmd, reg_we} = '0;
        cyc();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule